// File: doc/BRIEF.md
# Dual-Mode Issue Scheduler for a Wide Modular Multiplier

This block is the control unit of a pipelined modular multiplier that has nine stages (named I, A, B, C, D, E, F, G and H). It accepts one operation request at a time, with a field-width mode bit and an operation index. It then drives the stage enables that move the operation's slots through the datapath. The arithmetic itself lives elsewhere. The scheduler only decides which stage works on what in each cycle, tags every issued slot, and raises a strobe when a result leaves the pipe.

Narrow-field operations (192 to 256 bits) make one full-width pass through I, A, B, C, D, E, F and H, skipping G. One such operation can be accepted in every cycle. Wide-field operations (384 and 521 bits) are split into four half-operand sub-products, which are issued on back-to-back cycles. Each sub-product uses I, A, B and C once at full width. Stages D through H are then time-shared, a low half in one cycle and a high half in the next. A wide request is admitted at most once every eight cycles. A request that changes mode waits until every operation in flight has delivered its result.

Top module: `mmul_issue_sched`

## Requirements
- R1: After reset, `req_ready` is high for either mode, and all stage enables, half enables, `iss_vld` and `res_vld` are low.
- R2: A narrow operation accepted at clock edge e drives exactly one `stg_en` bit in each of the cycles that follow edge e+k, for k = 0..7. The bit order is I=0, A=1, B=2, C=3, D=4, E=5, F=6, G=7, H=8. The active bit is k for k < 7, and bit 8 (H) for k = 7. Bit 7 (G) is never used.
- R3: The result strobe `res_vld` of a narrow operation accepted at edge e is high in the cycle after edge e+8, carrying its index on `res_id`. Narrow requests presented on consecutive cycles are accepted with no gap.
- R4: A wide operation accepted at edge e issues its four slots in the cycles after edges e, e+1, e+2 and e+3. Each slot shows `iss_vld`=1, `iss_mode`=1 and the operation index. The `iss_sub` values are, in order, 0 (low×low), 1 (low×high), 2 (high×low) and 3 (high×high). A narrow issue shows `iss_mode`=0 and `iss_sub`=0.
- R5: Sub-product k of a wide operation accepted at edge e enables `stg_en` bit s (s = 0..3) after edge e+k+s. For split stage j (D=0, E=1, F=2, G=3, H=4), it enables `half_lo_en[j]` after edge e+k+4+2j and `half_hi_en[j]` after edge e+k+5+2j. Bits 4..8 of `stg_en` stay low in wide mode.
- R6: The result strobe of a wide operation accepted at edge e is high, for a single cycle, after edge e+20, with its index on `res_id`.
- R7: After a wide acceptance, `req_ready` for a wide request stays low for the next 7 cycles. The next wide operation is therefore accepted 8 edges later.
- R8: While any operation is in flight, a request of the other mode sees `req_ready` low. It rises in the cycle after the last result strobe, and the request is then accepted at once.
- R9: The narrow split-stage enables (`stg_en` bits 4..8) and the half enables are never high in the same cycle.
- R10: With `req_valid` low, nothing is issued and no result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request present |
| req_mode | input | 1 | 0 = narrow field, 1 = wide field |
| req_id | input | ID_W | Operation index |
| req_ready | output | 1 | Request accepted on this edge when valid |
| iss_vld | output | 1 | A slot enters stage I this cycle |
| iss_mode | output | 1 | Mode of the issued slot |
| iss_sub | output | 2 | Sub-product code of the issued slot |
| iss_id | output | ID_W | Operation index of the issued slot |
| stg_en | output | N_FULL+N_SPLIT | Full-width stage enables, I at bit 0 |
| half_lo_en | output | N_SPLIT | Low-half enables of split stages, D at bit 0 |
| half_hi_en | output | N_SPLIT | High-half enables of split stages, D at bit 0 |
| res_vld | output | 1 | Result leaves the pipeline |
| res_id | output | ID_W | Operation index of the result |

## Verification
Two functions can fall in the same cycle: retiring an older operation and feeding a younger one of the same mode into the pipe. In a stream of ten narrow requests, the strobe of the first result lands in the cycle in which the ninth request is issued. With two wide requests eight cycles apart, the first one's result appears while the second is in its low-half H work. A scoreboard queue holds the index and due cycle of every accepted operation. Each strobe is matched against the head of that queue, so a result that is lost, merged or mis-timed under this overlap shows up as a wrong index or cycle.

// File: rtl/mmul_sched_pkg.sv
package mmul_sched_pkg;

   // number of half-operand sub-products that make up one wide operation
   localparam int NSUB = 4;

   typedef enum logic {
      MODE_NARROW = 1'b0,
      MODE_WIDE   = 1'b1
   } fmode_e;

   // issue order of the sub-products of a wide operation
   typedef enum logic [1:0] {
      SP_LL = 2'd0,
      SP_LH = 2'd1,
      SP_HL = 2'd2,
      SP_HH = 2'd3
   } subprod_e;

   typedef struct packed {
      logic   vld;
      fmode_e mode;
   } pipe_tok_t;

endpackage

// File: rtl/mmul_sched_admit.sv
module mmul_sched_admit
   import mmul_sched_pkg::*;
#(
   parameter int LG_II = 8
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req_valid,
   input  fmode_e req_mode,
   input  logic   pipe_busy,
   output logic   req_ready,
   output logic   acc_narrow,
   output logic   acc_wide
);
   localparam int GAP_W = (LG_II > 2) ? $clog2(LG_II) : 1;
   localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(LG_II - 1);
   localparam int CHK_W = $clog2(LG_II + 1);
   localparam logic [CHK_W-1:0] CHK_SAT = CHK_W'(LG_II);
   localparam logic [CHK_W-1:0] CHK_MIN = CHK_W'(LG_II - 1);

   logic [GAP_W-1:0] gap_q;
   fmode_e           mode_q;
   logic             mode_ok, gap_ok;

   // a mode switch needs an empty pipe; wide requests also respect the gap
   always_comb begin
      mode_ok   = (req_mode == mode_q) || !pipe_busy;
      gap_ok    = (req_mode == MODE_NARROW) || (gap_q == '0);
      req_ready = mode_ok && gap_ok;
      acc_narrow = req_valid && req_ready && (req_mode == MODE_NARROW);
      acc_wide   = req_valid && req_ready && (req_mode == MODE_WIDE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         mode_q <= MODE_NARROW;
      end else begin
         if (acc_wide)
            gap_q <= GAP_RELOAD;
         else if (gap_q != '0)
            gap_q <= gap_q - 1'b1;
         if (acc_narrow || acc_wide)
            mode_q <= req_mode;
      end
   end

   // independent cycle counter since the last wide acceptance (checker only)
   logic [CHK_W-1:0] since_wide_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_wide_q <= CHK_SAT;
      else if (acc_wide)
         since_wide_q <= '0;
      else if (since_wide_q != CHK_SAT)
         since_wide_q <= since_wide_q + 1'b1;
   end

   p_wide_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_wide |-> (since_wide_q >= CHK_MIN))
      else $error("wide operations admitted too close together");

endmodule

// File: rtl/mmul_sched_issue.sv
module mmul_sched_issue
   import mmul_sched_pkg::*;
#(
   parameter int ID_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_narrow,
   input  logic            acc_wide,
   input  logic [ID_W-1:0] req_id,
   output logic            iss_vld,
   output fmode_e          iss_mode,
   output subprod_e        iss_sub,
   output logic [ID_W-1:0] iss_id
);
   localparam int CNT_W = $clog2(NSUB);
   localparam logic [CNT_W-1:0] LEFT_INIT = CNT_W'(NSUB - 1);

   logic [CNT_W-1:0] left_q;
   subprod_e         next_sub_q;
   logic [ID_W-1:0]  hold_id_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iss_vld    <= 1'b0;
         iss_mode   <= MODE_NARROW;
         iss_sub    <= SP_LL;
         iss_id     <= '0;
         left_q     <= '0;
         next_sub_q <= SP_LH;
         hold_id_q  <= '0;
      end else begin
         iss_vld <= 1'b0;
         if (acc_narrow) begin
            iss_vld  <= 1'b1;
            iss_mode <= MODE_NARROW;
            iss_sub  <= SP_LL;
            iss_id   <= req_id;
         end else if (acc_wide) begin
            iss_vld    <= 1'b1;
            iss_mode   <= MODE_WIDE;
            iss_sub    <= SP_LL;
            iss_id     <= req_id;
            left_q     <= LEFT_INIT;
            next_sub_q <= SP_LH;
            hold_id_q  <= req_id;
         end else if (left_q != '0) begin
            iss_vld    <= 1'b1;
            iss_mode   <= MODE_WIDE;
            iss_sub    <= next_sub_q;
            iss_id     <= hold_id_q;
            left_q     <= left_q - 1'b1;
            next_sub_q <= subprod_e'(next_sub_q + 2'd1);
         end
      end
   end

   p_sub_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_vld && iss_mode == MODE_WIDE && iss_sub != SP_LL)
      |-> ($past(iss_vld) && (2'($past(iss_sub) + 2'd1) == 2'(iss_sub))))
      else $error("wide sub-products out of order");

   p_no_issue_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_narrow || acc_wide) |-> (left_q == '0))
      else $error("request admitted while sub-products still pending");

endmodule

// File: rtl/mmul_sched_pipe.sv
module mmul_sched_pipe
   import mmul_sched_pkg::*;
#(
   parameter int N_FULL  = 4,
   parameter int N_SPLIT = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tok_vld,
   input  fmode_e                    tok_mode,
   output logic [N_FULL+N_SPLIT-1:0] stg_en,
   output logic [N_SPLIT-1:0]        half_lo_en,
   output logic [N_SPLIT-1:0]        half_hi_en
);
   localparam int N_STG    = N_FULL + N_SPLIT;
   localparam int SLOT_LEN = N_FULL + 2 * N_SPLIT;
   localparam int H_POS    = N_FULL + N_SPLIT - 2;   // narrow slot position of H

   pipe_tok_t tok_q [1:SLOT_LEN-1];
   pipe_tok_t at    [SLOT_LEN];

   assign at[0] = '{vld: tok_vld, mode: tok_mode};

   for (genvar i = 1; i < SLOT_LEN; i++) begin : g_tap
      assign at[i] = tok_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 1; i < SLOT_LEN; i++)
            tok_q[i] <= '{vld: 1'b0, mode: MODE_NARROW};
      end else begin
         tok_q[1] <= at[0];
         for (int i = 2; i < SLOT_LEN; i++)
            tok_q[i] <= tok_q[i-1];
      end
   end

   // unsplit stages: one slot per cycle in both modes
   for (genvar s = 0; s < N_FULL; s++) begin : g_full
      assign stg_en[s] = at[s].vld;
   end

   // split stages: full width for narrow, low/high halves for wide
   for (genvar j = 0; j < N_SPLIT; j++) begin : g_split
      if (j == N_SPLIT - 2) begin : g_skip
         assign stg_en[N_FULL+j] = 1'b0;
      end else if (j == N_SPLIT - 1) begin : g_last
         assign stg_en[N_FULL+j] = at[H_POS].vld && (at[H_POS].mode == MODE_NARROW);
      end else begin : g_mid
         assign stg_en[N_FULL+j] = at[N_FULL+j].vld && (at[N_FULL+j].mode == MODE_NARROW);
      end
      assign half_lo_en[j] = at[N_FULL+2*j].vld   && (at[N_FULL+2*j].mode   == MODE_WIDE);
      assign half_hi_en[j] = at[N_FULL+2*j+1].vld && (at[N_FULL+2*j+1].mode == MODE_WIDE);

      p_half_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
         half_lo_en[j] |=> half_hi_en[j])
         else $error("high half did not follow low half");
   end

   p_mode_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !((|stg_en[N_STG-1:N_FULL]) && (|{half_lo_en, half_hi_en})))
      else $error("narrow and wide work share the split stages");

endmodule

// File: rtl/mmul_sched_retire.sv
module mmul_sched_retire #(
   parameter int ID_W   = 4,
   parameter int SM_LAT = 8,
   parameter int LG_LAT = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_narrow,
   input  logic            acc_wide,
   input  logic [ID_W-1:0] req_id,
   output logic            res_vld,
   output logic [ID_W-1:0] res_id,
   output logic            pipe_busy
);
   // narrow tokens enter part-way down the line so both modes exit at one tap
   localparam int NI = LG_LAT - SM_LAT;

   logic [LG_LAT:0] vld_q;
   logic [ID_W-1:0] id_q [LG_LAT+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         vld_q <= {vld_q[LG_LAT-1:0], acc_wide};
         if (acc_narrow)
            vld_q[NI] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      id_q[0] <= req_id;
      for (int i = 1; i <= LG_LAT; i++)
         id_q[i] <= id_q[i-1];
      if (acc_narrow)
         id_q[NI] <= req_id;
   end

   assign res_vld   = vld_q[LG_LAT];
   assign res_id    = id_q[LG_LAT];
   assign pipe_busy = |vld_q;

   p_no_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_narrow |-> !(|vld_q[NI-1:0]))
      else $error("narrow operation would merge with a wide one");

endmodule

// File: rtl/mmul_issue_sched.sv
module mmul_issue_sched
   import mmul_sched_pkg::*;
#(
   parameter int ID_W    = 4,
   parameter int N_FULL  = 4,
   parameter int N_SPLIT = 5,
   parameter int LG_LAT  = 20,
   parameter int LG_II   = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic                      req_mode,
   input  logic [ID_W-1:0]           req_id,
   output logic                      req_ready,
   output logic                      iss_vld,
   output logic                      iss_mode,
   output logic [1:0]                iss_sub,
   output logic [ID_W-1:0]           iss_id,
   output logic [N_FULL+N_SPLIT-1:0] stg_en,
   output logic [N_SPLIT-1:0]        half_lo_en,
   output logic [N_SPLIT-1:0]        half_hi_en,
   output logic                      res_vld,
   output logic [ID_W-1:0]           res_id
);
   localparam int SM_LAT   = N_FULL + N_SPLIT - 1;
   localparam int LAST_USE = NSUB - 1 + N_FULL + 2 * N_SPLIT;

   if (ID_W < 1) begin : g_bad_id
      $error("ID_W must be at least 1");
   end
   if (N_FULL < 1 || N_SPLIT < 2) begin : g_bad_stages
      $error("need at least one unsplit and two split stages");
   end
   if (LG_LAT < LAST_USE || LG_LAT <= SM_LAT) begin : g_bad_lat
      $error("LG_LAT shorter than the wide occupancy of the pipe");
   end
   if (LG_II < NSUB) begin : g_bad_ii
      $error("LG_II must cover the issue of all sub-products");
   end

   logic     acc_narrow, acc_wide, pipe_busy;
   fmode_e   iss_mode_e;
   subprod_e iss_sub_e;

   mmul_sched_admit #(.LG_II(LG_II)) u_admit (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_mode   (fmode_e'(req_mode)),
      .pipe_busy  (pipe_busy),
      .req_ready  (req_ready),
      .acc_narrow (acc_narrow),
      .acc_wide   (acc_wide)
   );

   mmul_sched_issue #(.ID_W(ID_W)) u_issue (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_narrow (acc_narrow),
      .acc_wide   (acc_wide),
      .req_id     (req_id),
      .iss_vld    (iss_vld),
      .iss_mode   (iss_mode_e),
      .iss_sub    (iss_sub_e),
      .iss_id     (iss_id)
   );

   assign iss_mode = iss_mode_e;
   assign iss_sub  = iss_sub_e;

   mmul_sched_pipe #(.N_FULL(N_FULL), .N_SPLIT(N_SPLIT)) u_pipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .tok_vld    (iss_vld),
      .tok_mode   (iss_mode_e),
      .stg_en     (stg_en),
      .half_lo_en (half_lo_en),
      .half_hi_en (half_hi_en)
   );

   mmul_sched_retire #(.ID_W(ID_W), .SM_LAT(SM_LAT), .LG_LAT(LG_LAT)) u_retire (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_narrow (acc_narrow),
      .acc_wide   (acc_wide),
      .req_id     (req_id),
      .res_vld    (res_vld),
      .res_id     (res_id),
      .pipe_busy  (pipe_busy)
   );

endmodule

// File: tb/mmul_issue_sched_bench.sv
module mmul_issue_sched_bench;
   localparam int ID_W    = 4;
   localparam int N_FULL  = 4;
   localparam int N_SPLIT = 5;
   localparam int N_STG   = N_FULL + N_SPLIT;
   localparam int SM_LAT  = 8;
   localparam int LG_LAT  = 20;
   localparam int LG_II   = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_mode = 1'b0;
   logic [ID_W-1:0]   req_id = '0;
   logic              req_ready, iss_vld, iss_mode, res_vld;
   logic [1:0]        iss_sub;
   logic [ID_W-1:0]   iss_id, res_id;
   logic [N_STG-1:0]  stg_en;
   logic [N_SPLIT-1:0] half_lo_en, half_hi_en;

   mmul_issue_sched u_mmul_issue_sched (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_id(req_id), .req_ready(req_ready), .iss_vld(iss_vld),
      .iss_mode(iss_mode), .iss_sub(iss_sub), .iss_id(iss_id), .stg_en(stg_en),
      .half_lo_en(half_lo_en), .half_hi_en(half_hi_en), .res_vld(res_vld),
      .res_id(res_id)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int  checks = 0;
   int  fails = 0;
   bit  done = 1'b0;
   bit  overlap_seen = 1'b0;

   typedef struct {
      int    id;
      int    due;
      string tag;
   } exp_t;
   exp_t sb[$];

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // driver: present a request, wait for acceptance, push the expected result
   task automatic send(input bit mode, input int id, output int acc_cyc, output int waited);
      req_valid = 1'b1;
      req_mode  = mode;
      req_id    = ID_W'(id);
      waited    = 0;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
         waited++;
      end
      @(posedge clk);
      @(negedge clk);
      acc_cyc   = cyc;
      req_valid = 1'b0;
      sb.push_back('{id, cyc + (mode ? LG_LAT : SM_LAT), mode ? "R6" : "R3"});
   endtask

   // monitor: compare every result strobe with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (res_vld) begin
            if (sb.size() == 0) begin
               chk("R10", "unexpected result strobe", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(e.tag, "result id", int'(res_id), e.id);
               chk(e.tag, "result cycle", cyc, e.due);
            end
         end
         if (stg_en[7] || ((|stg_en[N_STG-1:N_FULL]) && (|{half_lo_en, half_hi_en})))
            overlap_seen = 1'b1;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int a1, a2, w, prev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1 reset state
      chk("R1", "ready narrow", int'(req_ready), 1);
      chk("R1", "stage enables", int'(stg_en), 0);
      chk("R1", "half enables", int'({half_lo_en, half_hi_en}), 0);
      chk("R1", "issue valid", int'(iss_vld), 0);
      chk("R1", "result valid", int'(res_vld), 0);
      req_mode = 1'b1;
      #1;
      chk("R1", "ready wide", int'(req_ready), 1);
      @(negedge clk);

      // single narrow operation: stage walk and mode-switch blocking
      send(1'b0, 3, a1, w);
      chk("R4", "narrow issue mode", int'(iss_mode), 0);
      chk("R4", "narrow issue sub", int'(iss_sub), 0);
      chk("R4", "narrow issue id", int'(iss_id), 3);
      req_mode = 1'b1;
      for (int o = 0; o <= 9; o++) begin
         int e;
         #1;
         e = (o < 7) ? (1 << o) : ((o == 7) ? (1 << 8) : 0);
         chk("R2", $sformatf("narrow stages at +%0d", o), int'(stg_en), e);
         chk("R8", $sformatf("wide ready after narrow +%0d", o), int'(req_ready), (o >= 9) ? 1 : 0);
         @(negedge clk);
      end

      // narrow stream, one per cycle; results overlap later issues
      prev = -1;
      for (int n = 0; n < 10; n++) begin
         send(1'b0, n, a1, w);
         chk("R3", "narrow stream wait", w, 0);
         if (prev >= 0) chk("R3", "narrow stream spacing", a1 - prev, 1);
         prev = a1;
      end
      repeat (12) @(negedge clk);

      // single wide operation: sub-products, split stages, spacing
      send(1'b1, 9, a1, w);
      req_mode = 1'b1;
      for (int o = 0; o <= 21; o++) begin
         int es, el, eh;
         #1;
         es = 0; el = 0; eh = 0;
         for (int s = 0; s < N_FULL; s++)
            if (o - s >= 0 && o - s <= 3) es |= (1 << s);
         for (int j = 0; j < N_SPLIT; j++)
            for (int k = 0; k < 4; k++) begin
               if (o == k + 4 + 2 * j) el |= (1 << j);
               if (o == k + 5 + 2 * j) eh |= (1 << j);
            end
         chk("R4", $sformatf("wide issue valid +%0d", o), int'(iss_vld), (o <= 3) ? 1 : 0);
         if (o <= 3) begin
            chk("R4", $sformatf("wide sub code +%0d", o), int'(iss_sub), o);
            chk("R4", "wide issue mode", int'(iss_mode), 1);
            chk("R4", "wide issue id", int'(iss_id), 9);
         end
         chk("R5", $sformatf("wide stage enables +%0d", o), int'(stg_en), es);
         chk("R5", $sformatf("wide low halves +%0d", o), int'(half_lo_en), el);
         chk("R5", $sformatf("wide high halves +%0d", o), int'(half_hi_en), eh);
         chk("R7", $sformatf("wide ready +%0d", o), int'(req_ready), (o >= 7) ? 1 : 0);
         @(negedge clk);
      end

      // two wide operations back to back, then a mode switch to narrow
      send(1'b1, 1, a1, w);
      send(1'b1, 2, a2, w);
      chk("R7", "wide acceptance spacing", a2 - a1, LG_II);
      req_mode = 1'b0;
      for (int o = 0; o <= 21; o++) begin
         #1;
         chk("R8", $sformatf("narrow ready after wide +%0d", o), int'(req_ready), (o >= 21) ? 1 : 0);
         @(negedge clk);
      end
      send(1'b0, 7, a1, w);
      chk("R8", "switch accepted at once", w, 0);
      repeat (12) @(negedge clk);

      // idle with valid low: nothing moves
      req_mode = 1'b0;
      for (int o = 0; o < 6; o++) begin
         req_id = ID_W'(o + 5);
         #1;
         chk("R10", "no issue while idle", int'(iss_vld), 0);
         chk("R10", "no result while idle", int'(res_vld), 0);
         @(negedge clk);
      end

      chk("R9", "split stage conflict seen", int'(overlap_seen), 0);
      chk("R6", "outstanding results", sb.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule